// File: doc/BRIEF.md
# System Controller Register Block

This block is a small register file that sits on a single-cycle 32-bit register port. It holds four registers. The first is a read-only status word that freezes the board strap pins once reset is released. The second is a soft-reset register whose bits start fixed-length reset pulses on 32 lines and then clear themselves. The third is a clock-control register whose gate bits switch peripheral clocks off when set. The fourth is a miscellaneous-control register that sets the PCI clock speed and the PCI clock output enable.

Software starts a reset by writing ones to the lines it wants to pulse. It never writes the bits back to zero. It can poll the same offset to see which pulses are still running. The line for the second CPU pulses on every write to the soft-reset register, whatever the written value.

The clock-gate bits use set-to-disable polarity. After power-up every bit is zero, so every peripheral clock is running.

Top module: `sysctl_regs`

## Requirements
- R1: The status word is read at offset 0x04. It holds the crystal-select strap in bit 30, the bus-speed code in bits 17:15 and the CPU-to-bus ratio code in bits 19:18, with all other bits zero. A write to 0x04 leaves it unchanged.
- R2: The strap pins are sampled on the first rising clock edge after rst_ni goes high. Later changes on the pins never reach the status word.
- R3: A write to offset 0x0C with bit n set drives soft_rst_o[n] high from the write edge on, for PULSE_CYCLES (default 16) cycles. The line then returns low with no further write.
- R4: Every write to offset 0x0C also starts a pulse on line 30, even when bit 30 of the written data is zero.
- R5: A read of offset 0x0C returns a 1 in each bit whose reset pulse is still running, and 0 elsewhere.
- R6: A new write that sets a line whose pulse is still running restarts that line's full PULSE_CYCLES count.
- R7: Clock-control register at 0x34. Bit k (1..13) gates clock clk_en_o[k-1]: writing 1 disables the clock and writing 0 enables it. After reset the register is zero and clk_en_o is all ones.
- R8: In the clock-control register, bit 16 drives pci_clkrun_o and bit 29 drives sec_clk_sel_o. All 32 bits read back as written, including bits that drive no output.
- R9: Miscellaneous-control register at 0x30. Bit 18 drives pci_66m_o (1 = 66 MHz, 0 = 33 MHz) and bit 17 drives pci_clk_oe_o. All bits read back as written, and the register resets to zero.
- R10: A read of any other offset returns zero. A write to any other offset changes no register and no output.
- R11: bus_rdata_o is registered. It takes the value of the addressed register on the edge that samples a read request (bus_req_i=1, bus_we_i=0) and otherwise holds its value. It is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_xtal_i | input | 1 | Crystal-select strap (1 = 30 MHz, 0 = 60 MHz) |
| strap_bus_speed_i | input | 3 | Bus-speed strap code |
| strap_cpu_ratio_i | input | 2 | CPU-to-bus ratio strap code |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| soft_rst_o | output | 32 | Self-clearing reset lines, active high |
| clk_en_o | output | 13 | Peripheral clock enables, active high |
| pci_clkrun_o | output | 1 | PCI clock-run enable |
| sec_clk_sel_o | output | 1 | Security clock ratio select |
| pci_66m_o | output | 1 | PCI 66 MHz select |
| pci_clk_oe_o | output | 1 | PCI clock output enable |

## Verification
The assertions check the following on every cycle:
- a soft-reset write raises its lines, and line 30, on the next cycle;
- a pulse never drops in a cycle where the same line was just written;
- the captured strap stays frozen;
- the clock and PCI control outputs move only after a write;
- an unmapped read yields zero.

Only the bench scenarios can show the exact pulse length, the restart of a running pulse, the read-back contents of each register, the set-to-disable mapping of gate bits onto enables, and the fact that pin changes after reset release never reach the status word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int N_RST    = 32;
  localparam int N_GATE   = 13;
  localparam int CPU1_BIT = 30;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SRST   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MISC   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CLK    = 8'h34;

  localparam int ST_XTAL_BIT  = 30;
  localparam int ST_SPEED_LSB = 15;
  localparam int ST_RATIO_LSB = 18;
  localparam int CLK_GATE_LSB = 1;
  localparam int CLK_RUN_BIT  = 16;
  localparam int CLK_SEC_BIT  = 29;
  localparam int MISC_OE_BIT  = 17;
  localparam int MISC_66_BIT  = 18;

  typedef struct packed {
    logic       xtal;
    logic [2:0] speed;
    logic [1:0] ratio;
  } strap_t;
endpackage

// File: rtl/sysctl_strap.sv
module sysctl_strap
  import sysctl_pkg::*;
#(
  parameter int DATA_W = sysctl_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strap_t            strap_i,
  output logic [DATA_W-1:0] status_o
);
  logic   captured_q;
  strap_t strap_q;

  // one-shot capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      captured_q <= 1'b0;
      strap_q    <= '0;
    end else if (!captured_q) begin
      captured_q <= 1'b1;
      strap_q    <= strap_i;
    end
  end

  always_comb begin
    status_o                    = '0;
    status_o[ST_XTAL_BIT]       = strap_q.xtal;
    status_o[ST_SPEED_LSB +: 3] = strap_q.speed;
    status_o[ST_RATIO_LSB +: 2] = strap_q.ratio;
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    captured_q |=> $stable(strap_q)); // R2
endmodule

// File: rtl/sysctl_rst_pulse.sv
module sysctl_rst_pulse #(
  parameter int N_LINES      = 32,
  parameter int PULSE_CYCLES = 16,
  parameter int FORCE_BIT    = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [N_LINES-1:0] set_i,
  output logic [N_LINES-1:0] active_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic             start;
    logic [CNT_W-1:0] cnt_q;

    if (g == FORCE_BIT) begin : g_forced
      assign start = wr_i;
    end else begin : g_plain
      assign start = wr_i & set_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (start)           cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
    end

    assign active_o[g] = (cnt_q != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && set_i[g]) |=> active_o[g]); // R3
    AST_NO_DROP_ON_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_o[g]) |-> !$past(start)); // R6
  end

  AST_FORCED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> active_o[FORCE_BIT]); // R4
endmodule

// File: rtl/sysctl_clk_ctrl.sv
module sysctl_clk_ctrl
  import sysctl_pkg::*;
#(
  parameter int DATA_W = sysctl_pkg::DATA_W,
  parameter int N_GATE = sysctl_pkg::N_GATE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reg_o,
  output logic [N_GATE-1:0] clk_en_o,
  output logic              clkrun_o,
  output logic              sec_sel_o
);
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (wr_i) reg_q <= wdata_i;
  end

  assign reg_o     = reg_q;
  // set-to-disable gating
  assign clk_en_o  = ~reg_q[CLK_GATE_LSB +: N_GATE];
  assign clkrun_o  = reg_q[CLK_RUN_BIT];
  assign sec_sel_o = reg_q[CLK_SEC_BIT];

  AST_GATE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> clk_en_o == ~$past(wdata_i[CLK_GATE_LSB +: N_GATE])); // R7
  AST_CLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({clk_en_o, clkrun_o, sec_sel_o})); // R10
endmodule

// File: rtl/sysctl_pci_ctrl.sv
module sysctl_pci_ctrl
  import sysctl_pkg::*;
#(
  parameter int DATA_W = sysctl_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reg_o,
  output logic              pci_66m_o,
  output logic              pci_oe_o
);
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (wr_i) reg_q <= wdata_i;
  end

  assign reg_o     = reg_q;
  assign pci_66m_o = reg_q[MISC_66_BIT];
  assign pci_oe_o  = reg_q[MISC_OE_BIT];

  AST_PCI_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pci_66m_o == $past(wdata_i[MISC_66_BIT])); // R9
  AST_PCI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({pci_66m_o, pci_oe_o})); // R9
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_xtal_i,
  input  logic [2:0]        strap_bus_speed_i,
  input  logic [1:0]        strap_cpu_ratio_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_RST-1:0]  soft_rst_o,
  output logic [N_GATE-1:0] clk_en_o,
  output logic              pci_clkrun_o,
  output logic              sec_clk_sel_o,
  output logic              pci_66m_o,
  output logic              pci_clk_oe_o
);
  logic              hit_status, hit_srst, hit_misc, hit_clk, hit_any;
  logic              wr, rd;
  logic [DATA_W-1:0] status_w, clk_reg_w, misc_reg_w, rd_mux;
  logic [DATA_W-1:0] rdata_q;
  strap_t            strap_w;

  assign hit_status = (bus_addr_i == OFS_STATUS);
  assign hit_srst   = (bus_addr_i == OFS_SRST);
  assign hit_misc   = (bus_addr_i == OFS_MISC);
  assign hit_clk    = (bus_addr_i == OFS_CLK);
  assign hit_any    = hit_status | hit_srst | hit_misc | hit_clk;
  assign wr         = bus_req_i & bus_we_i;
  assign rd         = bus_req_i & ~bus_we_i;

  assign strap_w = '{xtal: strap_xtal_i, speed: strap_bus_speed_i, ratio: strap_cpu_ratio_i};

  sysctl_strap #(.DATA_W(DATA_W)) u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_w),
    .status_o (status_w)
  );

  sysctl_rst_pulse #(
    .N_LINES      (N_RST),
    .PULSE_CYCLES (PULSE_CYCLES),
    .FORCE_BIT    (CPU1_BIT)
  ) u_rst_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr & hit_srst),
    .set_i    (bus_wdata_i),
    .active_o (soft_rst_o)
  );

  sysctl_clk_ctrl #(.DATA_W(DATA_W), .N_GATE(N_GATE)) u_clk_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr & hit_clk),
    .wdata_i   (bus_wdata_i),
    .reg_o     (clk_reg_w),
    .clk_en_o  (clk_en_o),
    .clkrun_o  (pci_clkrun_o),
    .sec_sel_o (sec_clk_sel_o)
  );

  sysctl_pci_ctrl #(.DATA_W(DATA_W)) u_pci_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr & hit_misc),
    .wdata_i   (bus_wdata_i),
    .reg_o     (misc_reg_w),
    .pci_66m_o (pci_66m_o),
    .pci_oe_o  (pci_clk_oe_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_status: rd_mux = status_w;
      hit_srst:   rd_mux = soft_rst_o;
      hit_misc:   rd_mux = misc_reg_w;
      hit_clk:    rd_mux = clk_reg_w;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !hit_any) |=> bus_rdata_o == '0); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o)); // R11
  AST_STATUS_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_status) |=> bus_rdata_o[14:0] == '0); // R1
endmodule

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal = 1'b1;
  logic [2:0]  speed = 3'd5;
  logic [1:0]  ratio = 2'd2;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, srst;
  logic [12:0] clk_en;
  logic        clkrun, secsel, p66, poe;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [31:0] STRAP_EXP = (32'd1 << 30) | (32'd2 << 18) | (32'd5 << 15);

  always #4 clk = ~clk;

  sysctl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .strap_xtal_i(xtal), .strap_bus_speed_i(speed), .strap_cpu_ratio_i(ratio),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .soft_rst_o(srst), .clk_en_o(clk_en),
    .pci_clkrun_o(clkrun), .sec_clk_sel_o(secsel),
    .pci_66m_o(p66), .pci_clk_oe_o(poe)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R11 rdata reset", rdata, 32'h0);
    chk("R3 srst reset", srst, 32'h0);
    chk("R7 clk_en reset", {19'h0, clk_en}, 32'h1fff);
    chk("R9 pci reset", {28'h0, clkrun, secsel, p66, poe}, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    xtal = 0; speed = 3'd1; ratio = 2'd1;   // R2 pins move after capture
    bus_read(8'h04, d);
    chk("R2 strap frozen", d, STRAP_EXP);
    bus_write(8'h04, 32'hffff_ffff);
    bus_read(8'h04, d);
    chk("R1 status read-only", d, STRAP_EXP);
  endtask

  task automatic t_pulse();
    bus_write(8'h0C, 32'h0000_0020);
    chk("R3 pulse start", srst, 32'h4000_0020);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R3 pulse held", {31'h0, srst[5]}, 32'h1);
    end
    @(negedge clk);
    chk("R3 pulse cleared", srst, 32'h0);
  endtask

  task automatic t_forced();
    bus_write(8'h0C, 32'h0);
    chk("R4 cpu1 forced", srst, 32'h4000_0000);
    idle(20);
    chk("R4 cpu1 cleared", srst, 32'h0);
  endtask

  task automatic t_status_read();
    logic [31:0] d;
    bus_write(8'h0C, 32'h0000_0005);
    bus_read(8'h0C, d);
    chk("R5 active readback", d, 32'h4000_0005);
    idle(20);
    bus_read(8'h0C, d);
    chk("R5 idle readback", d, 32'h0);
  endtask

  task automatic t_restart();
    bus_write(8'h0C, 32'h0000_0008);
    idle(10);
    chk("R6 still active", {31'h0, srst[3]}, 32'h1);
    bus_write(8'h0C, 32'h0000_0008);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R6 restarted held", {31'h0, srst[3]}, 32'h1);
    end
    @(negedge clk);
    chk("R6 restarted cleared", {31'h0, srst[3]}, 32'h0);
  endtask

  task automatic t_clk();
    logic [31:0] d, v;
    v = (32'd1 << 2) | (32'd1 << 13) | (32'd1 << 16) | (32'd1 << 29) | 32'd1 | (32'd1 << 15);
    bus_write(8'h34, v);
    chk("R7 gate polarity", {19'h0, clk_en}, 32'h0ffd);
    chk("R8 clkrun/sec", {30'h0, clkrun, secsel}, 32'h3);
    bus_read(8'h34, d);
    chk("R8 clk readback", d, v);
    bus_write(8'h34, 32'h0000_3ffe);
    chk("R7 all gated", {19'h0, clk_en}, 32'h0);
    bus_write(8'h34, 32'h0);
    chk("R7 all running", {19'h0, clk_en}, 32'h1fff);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    bus_write(8'h30, 32'h0004_0001);
    chk("R9 66m set", {30'h0, p66, poe}, 32'h2);
    bus_read(8'h30, d);
    chk("R9 misc readback", d, 32'h0004_0001);
    bus_write(8'h30, 32'h0002_0000);
    chk("R9 oe set 33m", {30'h0, p66, poe}, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(8'h34, 32'h0000_0010);
    bus_write(8'h10, 32'hffff_ffff);
    bus_write(8'h38, 32'hffff_ffff);
    chk("R10 no side effect clk", {19'h0, clk_en}, 32'h1ff7);
    chk("R10 no side effect pci", {30'h0, p66, poe}, 32'h1);
    chk("R10 no reset pulse", srst, 32'h0);
    bus_read(8'h10, d);
    chk("R10 unmapped read", d, 32'h0);
    bus_read(8'h34, d);
    chk("R10 clk unchanged", d, 32'h0000_0010);
    idle(3);
    chk("R11 rdata holds", rdata, 32'h0000_0010);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset_state();
    t_status();
    t_pulse();
    t_forced();
    t_status_read();
    idle(20);
    t_restart();
    idle(20);
    t_clk();
    t_misc();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule